// File: doc/BRIEF.md
# Line-Doubling Framebuffer Scan Addresser

This block produces the framebuffer read addresses for a video output path in which every stored pixel row appears on two consecutive scanlines. It follows the scanline sequence from two timing strobes: a frame-start pulse and a line-done pulse. It also takes an active-region level that marks the part of each scanline in which fetches may be issued. For each line it issues up to a fixed number of single-cycle read requests. Each request carries a linear address, and the address counter returns to zero once a whole frame of stored rows has been read.

Two doubling schemes are selected by a parameter. In replay mode, reads are made only on even scanlines. Each returned byte is pushed into one half of an external pair of line FIFOs, and the output side replays that half on the following odd scanline while the other half is being filled. On odd lines the counter holds and memory is left idle. In rewind mode there are no FIFOs. The counter records the address of the first fetch of each even line, and jumps back to that address when the even line ends, so the odd line reads the same row again.

Memory read data is taken to arrive exactly one clock after its request, and it is forwarded straight to the FIFO write port in that cycle.

Top module: `lnd_scan_addr`

## Requirements
- R1: A request (`rd_req`=1) is issued only in a cycle where `hactive`=1 and neither strobe is high. At most FETCH_PER_LINE requests are issued per scanline. Each request advances `rd_addr` by one in the following cycle.
- R2: In replay mode (MODE=MODE_REPLAY), no request and no FIFO write is made on an odd scanline. An odd scanline is one that follows an odd number of line-done pulses since the last frame start.
- R3: A request at address ROWS_PER_FRAME*FETCH_PER_LINE-1 is followed by `rd_addr`=0.
- R4: In rewind mode (MODE=MODE_REWIND), `rd_addr` is set at the end of an even scanline to the address of that line's first request. The odd scanline then issues requests through the same addresses.
- R5: In replay mode, `fifo_wr` is 1 in exactly the cycles that follow a request, with `fifo_wdata` equal to `rd_data` in that cycle. In rewind mode, `fifo_wr` stays 0.
- R6: In replay mode, the fill bank starts at 0 after reset or frame start and toggles at the end of each odd scanline. `fifo_bank` gives the bank that was in effect when the written byte was requested. In rewind mode, `fifo_bank` stays 0.
- R7: A frame-start pulse sets `rd_addr` to 0, makes the next line even and clears the per-line fetch count, whatever the current state. No request is issued in that cycle.
- R8: While `rst_n` is 0, `rd_addr` is 0, `fifo_wr` is 0 and `fifo_bank` is 0.
- R9: A line-done pulse ends the current scanline and restarts the per-line fetch count. No request is issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| line_done | input | 1 | One-cycle pulse at the end of each scanline |
| hactive | input | 1 | High during the region of a scanline where fetches are allowed |
| rd_req | output | 1 | Read request, combinational from state and inputs |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | DATA_W | Read data, valid one cycle after `rd_req` |
| fifo_wr | output | 1 | Line FIFO write strobe |
| fifo_wdata | output | DATA_W | Line FIFO write data |
| fifo_bank | output | 1 | Which FIFO of the pair is being written |

## Verification
The bench builds two instances with FETCH_PER_LINE=6, ROWS_PER_FRAME=3, ADDR_W=5 and DATA_W=8, one in replay mode and one in rewind mode, and drives both with the same strobes. The short line and frame put the wrap at address 17 within a handful of line pairs. That lets many wraps, rewinds that land just before a wrap, and bank toggles happen in a short run. Random gaps in the active region and frame-start pulses landing in the middle of a line cover lines that end with fewer than the full fetch count, and resets from arbitrary states.

// File: rtl/lnd_pkg.sv
package lnd_pkg;

    typedef enum logic {
        MODE_REPLAY = 1'b0,
        MODE_REWIND = 1'b1
    } mode_e;

endpackage

// File: rtl/lnd_line_track.sv
module lnd_line_track
    import lnd_pkg::*;
#(
    parameter int    FETCH_PER_LINE = 320,
    parameter mode_e MODE           = MODE_REPLAY,
    localparam int   CNT_W          = $clog2(FETCH_PER_LINE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_done,
    input  logic             hactive,
    output logic             issue,
    output logic             first_fetch,
    output logic             line_odd,
    output logic             fill_bank,
    output logic [CNT_W-1:0] fetch_cnt
);

    typedef struct packed {
        logic             odd;
        logic             bank;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic room;
    logic parity_ok;

    always_comb begin
        room        = (st_q.cnt < CNT_W'(FETCH_PER_LINE));
        parity_ok   = (MODE == MODE_REWIND) || !st_q.odd;
        issue       = hactive && !line_done && !frame_start && room && parity_ok;
        first_fetch = issue && (st_q.cnt == '0) && !st_q.odd;

        st_d = st_q;
        if (frame_start) begin
            st_d = '0;
        end else if (line_done) begin
            st_d.odd = !st_q.odd;
            st_d.cnt = '0;
            if (st_q.odd) begin
                st_d.bank = !st_q.bank;
            end
        end else if (issue) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_odd  = st_q.odd;
    assign fill_bank = st_q.bank;
    assign fetch_cnt = st_q.cnt;

endmodule

// File: rtl/lnd_addr_gen.sv
module lnd_addr_gen
    import lnd_pkg::*;
#(
    parameter int    ADDR_W  = 17,
    parameter int    LAST    = 76799,
    parameter mode_e MODE    = MODE_REPLAY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_done,
    input  logic              line_odd,
    input  logic              issue,
    input  logic              first_fetch,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] row_start
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] start;
    } ag_t;

    ag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d = '0;
        end else if (line_done) begin
            if ((MODE == MODE_REWIND) && !line_odd) begin
                st_d.addr = st_q.start;
            end
        end else if (issue) begin
            if (first_fetch) begin
                st_d.start = st_q.addr;
            end
            st_d.addr = (st_q.addr == LAST_A) ? '0 : st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr      = st_q.addr;
    assign row_start = st_q.start;

endmodule

// File: rtl/lnd_wr_stage.sv
module lnd_wr_stage
    import lnd_pkg::*;
#(
    parameter int    DATA_W = 8,
    parameter mode_e MODE   = MODE_REPLAY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              fill_bank,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_bank
);

    generate
        if (MODE == MODE_REPLAY) begin : g_replay
            typedef struct packed {
                logic wr;
                logic bank;
            } ws_t;

            ws_t st_d, st_q;

            always_comb begin
                st_d.wr   = issue;
                st_d.bank = fill_bank;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign fifo_wr   = st_q.wr;
            assign fifo_bank = st_q.bank;
        end else begin : g_rewind
            assign fifo_wr   = 1'b0;
            assign fifo_bank = 1'b0;
        end
    endgenerate

    assign fifo_wdata = rd_data;

endmodule

// File: rtl/lnd_scan_addr.sv
module lnd_scan_addr
    import lnd_pkg::*;
#(
    parameter int    FETCH_PER_LINE = 320,
    parameter int    ROWS_PER_FRAME = 240,
    parameter int    ADDR_W         = 17,
    parameter int    DATA_W         = 8,
    parameter mode_e MODE           = MODE_REPLAY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_done,
    input  logic              hactive,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_bank
);

    localparam int LAST  = ROWS_PER_FRAME * FETCH_PER_LINE - 1;
    localparam int CNT_W = $clog2(FETCH_PER_LINE + 1);

    logic              issue;
    logic              first_fetch;
    logic              line_odd;
    logic              fill_bank;
    logic [CNT_W-1:0]  fetch_cnt;
    logic [ADDR_W-1:0] row_start;

    lnd_line_track #(
        .FETCH_PER_LINE (FETCH_PER_LINE),
        .MODE           (MODE)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_done   (line_done),
        .hactive     (hactive),
        .issue       (issue),
        .first_fetch (first_fetch),
        .line_odd    (line_odd),
        .fill_bank   (fill_bank),
        .fetch_cnt   (fetch_cnt)
    );

    lnd_addr_gen #(
        .ADDR_W (ADDR_W),
        .LAST   (LAST),
        .MODE   (MODE)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_done   (line_done),
        .line_odd    (line_odd),
        .issue       (issue),
        .first_fetch (first_fetch),
        .addr        (rd_addr),
        .row_start   (row_start)
    );

    lnd_wr_stage #(
        .DATA_W (DATA_W),
        .MODE   (MODE)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .fill_bank  (fill_bank),
        .rd_data    (rd_data),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .fifo_bank  (fifo_bank)
    );

    assign rd_req = issue;

endmodule

// File: rtl/lnd_scan_chk.sv
module lnd_scan_chk
    import lnd_pkg::*;
#(
    parameter int    FETCH_PER_LINE = 320,
    parameter int    ROWS_PER_FRAME = 240,
    parameter int    ADDR_W         = 17,
    parameter mode_e MODE           = MODE_REPLAY,
    localparam int   CNT_W          = $clog2(FETCH_PER_LINE + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              line_done,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              fifo_wr,
    input logic              fifo_bank,
    input logic              line_odd,
    input logic              fill_bank,
    input logic [CNT_W-1:0]  fetch_cnt,
    input logic [ADDR_W-1:0] row_start
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(ROWS_PER_FRAME * FETCH_PER_LINE - 1);

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_addr != LAST_A) |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cnt <= CNT_W'(FETCH_PER_LINE));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_addr == LAST_A) |=> (rd_addr == '0));

    p_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (rd_addr == '0 && !line_odd && fetch_cnt == '0));

    p_strobe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done || frame_start) |-> !rd_req);

    generate
        if (MODE == MODE_REPLAY) begin : g_replay_chk
            p_odd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
                line_odd |-> !rd_req);

            p_wr_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
                rd_req |=> fifo_wr);

            p_no_stray_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_req |=> !fifo_wr);

            p_bank_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (line_done && line_odd && !frame_start) |=> (fill_bank != $past(fill_bank)));

            p_bank_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
                rd_req |=> (fifo_bank == $past(fill_bank)));
        end else begin : g_rewind_chk
            p_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (line_done && !line_odd && !frame_start) |=> (rd_addr == $past(row_start)));

            p_no_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !fifo_wr && !fifo_bank);
        end
    endgenerate

endmodule

bind lnd_scan_addr lnd_scan_chk #(
    .FETCH_PER_LINE (FETCH_PER_LINE),
    .ROWS_PER_FRAME (ROWS_PER_FRAME),
    .ADDR_W         (ADDR_W),
    .MODE           (MODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_done   (line_done),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .fifo_wr     (fifo_wr),
    .fifo_bank   (fifo_bank),
    .line_odd    (line_odd),
    .fill_bank   (fill_bank),
    .fetch_cnt   (fetch_cnt),
    .row_start   (row_start)
);

// File: tb/tb_lnd_scan_addr.sv
module tb_lnd_scan_addr;
    import lnd_pkg::*;

    localparam int F    = 6;
    localparam int ROWS = 3;
    localparam int AW   = 5;
    localparam int DW   = 8;
    localparam int LAST = F * ROWS - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic line_done = 1'b0;
    logic hactive = 1'b0;

    logic          req    [2];
    logic [AW-1:0] addr   [2];
    logic [DW-1:0] rdat   [2];
    logic          wr     [2];
    logic [DW-1:0] wdat   [2];
    logic          bank   [2];

    always #4 clk = ~clk;

    lnd_scan_addr #(.FETCH_PER_LINE(F), .ROWS_PER_FRAME(ROWS), .ADDR_W(AW),
                    .DATA_W(DW), .MODE(MODE_REPLAY)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_done(line_done),
        .hactive(hactive), .rd_req(req[0]), .rd_addr(addr[0]), .rd_data(rdat[0]),
        .fifo_wr(wr[0]), .fifo_wdata(wdat[0]), .fifo_bank(bank[0]));

    lnd_scan_addr #(.FETCH_PER_LINE(F), .ROWS_PER_FRAME(ROWS), .ADDR_W(AW),
                    .DATA_W(DW), .MODE(MODE_REWIND)) dut_rw (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_done(line_done),
        .hactive(hactive), .rd_req(req[1]), .rd_addr(addr[1]), .rd_data(rdat[1]),
        .fifo_wr(wr[1]), .fifo_wdata(wdat[1]), .fifo_bank(bank[1]));

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 11) ^ 8'hA5);
    endfunction

    // memory with one cycle of read latency
    always @(posedge clk) begin
        rdat[0] <= pat(int'(addr[0]));
        rdat[1] <= pat(int'(addr[1]));
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state per instance: 0 replay, 1 rewind
    int m_addr [2];
    int m_start[2];
    int m_cnt  [2];
    bit m_odd  [2];
    bit m_bank [2];
    bit m_wr   [2];
    int m_wa   [2];
    bit m_wb   [2];
    bit m_wrap [2];
    bit m_fs   [2];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            m_addr[m] = 0; m_start[m] = 0; m_cnt[m] = 0; m_odd[m] = 0;
            m_bank[m] = 0; m_wr[m] = 0; m_wa[m] = 0; m_wb[m] = 0;
            m_wrap[m] = 0; m_fs[m] = 0;
        end
    endtask

    task automatic cyc(input bit a, input bit le, input bit fs);
        @(negedge clk);
        hactive = a; line_done = le; frame_start = fs;
        #1;
        for (int m = 0; m < 2; m++) begin
            bit    ereq;
            string rtag;
            ereq = a && !le && !fs && (m_cnt[m] < F) && (m == 1 || !m_odd[m]);
            rtag = fs ? "R7" : le ? "R9" : (m == 0 && m_odd[m]) ? "R2" : "R1";
            chk(req[m] == ereq, rtag, "rd_req", int'(req[m]), int'(ereq));
            if (ereq) begin
                string atag;
                atag = m_fs[m] ? "R7" : m_wrap[m] ? "R3" : (m == 1 && m_odd[m]) ? "R4" : "R1";
                chk(int'(addr[m]) == m_addr[m], atag, "rd_addr", int'(addr[m]), m_addr[m]);
            end
            chk(wr[m] == m_wr[m], "R5", "fifo_wr", int'(wr[m]), int'(m_wr[m]));
            if (m_wr[m]) begin
                chk(wdat[m] == pat(m_wa[m]), "R5", "fifo_wdata", int'(wdat[m]), int'(pat(m_wa[m])));
            end
            chk(bank[m] == (m == 0 ? m_wb[m] : 1'b0), "R6", "fifo_bank",
                int'(bank[m]), int'(m == 0 ? m_wb[m] : 1'b0));
            // advance reference for the coming edge
            m_wr[m] = (m == 0) && ereq;
            m_wa[m] = m_addr[m];
            m_wb[m] = (m == 0) ? m_bank[m] : 1'b0;
            m_wrap[m] = 1'b0;
            m_fs[m] = 1'b0;
            if (fs) begin
                m_addr[m] = 0; m_start[m] = 0; m_cnt[m] = 0; m_odd[m] = 0; m_bank[m] = 0;
                m_fs[m] = 1'b1;
            end else if (le) begin
                if (m == 1 && !m_odd[m]) m_addr[m] = m_start[m];
                if (m_odd[m]) m_bank[m] = !m_bank[m];
                m_odd[m] = !m_odd[m];
                m_cnt[m] = 0;
            end else if (ereq) begin
                if (m_cnt[m] == 0 && !m_odd[m]) m_start[m] = m_addr[m];
                m_wrap[m] = (m_addr[m] == LAST);
                m_addr[m] = (m_addr[m] == LAST) ? 0 : m_addr[m] + 1;
                m_cnt[m]++;
            end
        end
    endtask

    task automatic line(input int len, input int pct);
        for (int i = 0; i < len; i++) cyc(($urandom % 100) < pct, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        chk(addr[0] == '0 && addr[1] == '0, "R8", "reset rd_addr", int'(addr[0]), 0);
        chk(!wr[0] && !wr[1], "R8", "reset fifo_wr", int'(wr[0]), 0);
        chk(!bank[0] && !bank[1], "R8", "reset fifo_bank", int'(bank[0]), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // directed: full lines across several wraps (R3, R4, R6)
        cyc(1'b0, 1'b0, 1'b1);
        for (int l = 0; l < 14; l++) line(F + 3, 100);
        // directed: active held through a strobe, and excess active cycles (R9, R1)
        for (int l = 0; l < 4; l++) begin
            for (int i = 0; i < F + 4; i++) cyc(1'b1, 1'b0, 1'b0);
            cyc(1'b1, 1'b1, 1'b0);
        end
        // directed: frame start in mid-line, with active high (R7)
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        line(F + 2, 100);
        line(F + 2, 100);
        // random lines with gaps and occasional frame starts
        for (int l = 0; l < 600; l++) begin
            int len;
            len = 3 + int'($urandom % 10);
            for (int i = 0; i < len; i++) begin
                bit fs;
                fs = ($urandom % 100) < 2;
                cyc(($urandom % 100) < 75, 1'b0, fs);
            end
            cyc(($urandom % 2) == 1, 1'b1, 1'b0);
        end
        // mid-run reset from an arbitrary state (R8)
        @(negedge clk);
        rst_n = 1'b0; hactive = 1'b0; line_done = 1'b0; frame_start = 1'b0;
        @(negedge clk);
        #1;
        chk(addr[0] == '0 && addr[1] == '0, "R8", "rd_addr in reset", int'(addr[0]), 0);
        chk(!wr[0] && !bank[0], "R8", "fifo_wr in reset", int'(wr[0]), 0);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int l = 0; l < 8; l++) line(F + 1, 90);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule